// File: doc/BRIEF.md
# Accumulator Status and Saturation Unit

This block sits behind the arithmetic stage of a fixed-point signal-processing datapath and owns two 36-bit accumulators. Each accumulator carries four guard bits above a 32-bit value, with bit 35 as the sign. A result arrives either as a 32-bit product, which is first scaled by a programmable alignment, or as an already formed 37-bit result whose top bit is the true carry-out. The unit stores the value into the selected accumulator. When the four guard bits disagree with bit 31 it clamps the value to the largest 32-bit magnitude of the right sign, unless clamping is switched off for that accumulator. It also records overflow, zero and negative conditions in a 16-bit status word.

A 16-bit control word selects the product scaling and holds per-accumulator saturation-disable and low-half clear-disable bits. A high-part load replaces bits 35..16 of an accumulator and clears the low half unless the clear-disable bit for that accumulator is set. Software may overwrite the status word at any time. Such a write replaces all 16 bits and wins over a flag update in the same cycle. All outputs are registered and change on the clock edge that samples the request.

Top module: `acc_sat_unit`

## Requirements
- R1: After reset both accumulators, the status word and the control word read zero.
- R2: A control write keeps bits 8..0 of the written data; bits 15..9 always read zero.
- R3: For a product operation, control bits 1..0 scale the sign-extended 32-bit product: 00 passes it unchanged, 01 shifts it right arithmetically by two, 10 multiplies it by four, 11 multiplies it by two. Vacated low bits are zero.
- R4: The 32-bit overflow flag is set when bits 35..32 of the result are not all equal to bit 31. The flag is stored in status bit 9 for an operation on accumulator 0 and in status bit 4 for accumulator 1. The flag of the other accumulator is left unchanged.
- R5: On a 32-bit overflow with saturation enabled, the accumulator loads 0x07FFFFFFF if bit 35 is 0 and 0xF80000000 if bit 35 is 1. Saturation is enabled for accumulator 0 when control bit 2 is 0 and for accumulator 1 when control bit 3 is 0. With saturation disabled, the unclamped 36-bit value is stored.
- R6: Status bit 13 is set by an operation whose 37-bit result has bit 36 different from bit 35, and cleared by one where they match.
- R7: Status bit 14 is set when the stored 36-bit value is zero. Status bit 15 equals bit 35 of the stored value.
- R8: A high-part load writes bits 35..16 from the result. The low 16 bits become zero unless the clear-disable bit is set: control bit 4 for accumulator 0, control bit 5 for accumulator 1. When the clear-disable bit is set, the low 16 bits keep their old value. Control bit 6 has no effect on either accumulator.
- R9: A status write replaces all 16 bits with the written data, even when an operation is flagged in the same cycle. The accumulator is still written by that operation.
- R10: In a cycle without the operation strobe or a status write, the accumulators and the status word hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation strobe |
| op_dest | input | 1 | Destination accumulator (0 or 1) |
| op_src_prod | input | 1 | 1: use the aligned product, 0: use op_res |
| op_hi_only | input | 1 | Load only bits 35..16 (high-part load) |
| op_prod | input | 32 | Product from the multiplier |
| op_res | input | 37 | Formed result including carry-out bit 36 |
| ctl_we | input | 1 | Control word write enable |
| ctl_wdata | input | 16 | Control word write data |
| sw_we | input | 1 | Status word write enable |
| sw_wdata | input | 16 | Status word write data |
| acc0 | output | 36 | Accumulator 0 |
| acc1 | output | 36 | Accumulator 1 |
| status | output | 16 | Status word |
| ctl | output | 16 | Control word |

## Verification
The hardest state to reach from the ports is a high-part load combined with a set clear-disable bit. That case only shows anything when the accumulator already holds non-zero low bits, and those bits must survive while the high part changes. The stimulus first loads a full value with a recognisable low half, then issues the high-part load under each control setting. It compares the whole 36-bit result against the merged value. A status write colliding with an operation is also forced on purpose. In that cycle the accumulator must change while the status word must not follow the operation.

// File: rtl/acc_sat_pkg.sv
package acc_sat_pkg;
  localparam int ACC_W    = 36;
  localparam int PROD_W   = 32;
  localparam int WORD_W   = 16;
  localparam int HALF_W   = 16;
  localparam int NUM_ACC  = 2;
  localparam int GUARD_W  = ACC_W - PROD_W;
  localparam int DEST_W   = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1;
  localparam int CTL_USED = 9;
  localparam int EXT_W    = ACC_W + 1;

  // control word field positions
  localparam int CTL_ALN_LO = 0;
  localparam int CTL_SAT_LO = 2;
  localparam int CTL_CLR_LO = 4;

  // status word flag positions
  localparam int ST_NEG  = 15;
  localparam int ST_ZERO = 14;
  localparam int ST_LOVF = 13;
  localparam int OVF_POS [NUM_ACC] = '{9, 4};

  typedef enum logic [1:0] {
    ALN_P    = 2'b00,
    ALN_DIV4 = 2'b01,
    ALN_MUL4 = 2'b10,
    ALN_MUL2 = 2'b11
  } align_e;

  function automatic logic [EXT_W-1:0] align_product(input logic [PROD_W-1:0] p,
                                                     input align_e mode);
    logic [EXT_W-1:0] ext;
    ext = {{(EXT_W-PROD_W){p[PROD_W-1]}}, p};
    case (mode)
      ALN_DIV4: align_product = {ext[EXT_W-1], ext[EXT_W-1], ext[EXT_W-1:2]};
      ALN_MUL4: align_product = {ext[EXT_W-3:0], 2'b00};
      ALN_MUL2: align_product = {ext[EXT_W-2:0], 1'b0};
      default:  align_product = ext;
    endcase
  endfunction

  function automatic logic guard_mismatch(input logic [ACC_W-1:0] v);
    guard_mismatch = (v[ACC_W-1:PROD_W] != {GUARD_W{v[PROD_W-1]}});
  endfunction

  function automatic logic [ACC_W-1:0] clamp_value(input logic neg);
    if (neg) clamp_value = {{(GUARD_W+1){1'b1}}, {(PROD_W-1){1'b0}}};
    else     clamp_value = {{(GUARD_W+1){1'b0}}, {(PROD_W-1){1'b1}}};
  endfunction
endpackage

// File: rtl/acc_ctl_reg.sv
module acc_ctl_reg
  import acc_sat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] ctl,
  output align_e            align_mode,
  output logic [NUM_ACC-1:0] sat_dis,
  output logic [NUM_ACC-1:0] clr_dis
);
  logic [CTL_USED-1:0] ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctl_q <= '0;
    else if (we) ctl_q <= wdata[CTL_USED-1:0];
  end

  assign ctl        = {{(WORD_W-CTL_USED){1'b0}}, ctl_q};
  assign align_mode = align_e'(ctl_q[CTL_ALN_LO +: 2]);
  assign sat_dis    = ctl_q[CTL_SAT_LO +: NUM_ACC];
  assign clr_dis    = ctl_q[CTL_CLR_LO +: NUM_ACC];
endmodule

// File: rtl/acc_lane.sv
module acc_lane
  import acc_sat_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [EXT_W-1:0] val,
  input  logic             hi_only,
  input  logic             sat_dis,
  input  logic             clr_dis,
  output logic [ACC_W-1:0] acc,
  output logic             ovf32,
  output logic             lovf,
  output logic             is_zero,
  output logic             is_neg
);
  logic [ACC_W-1:0] raw;
  logic [ACC_W-1:0] cand;
  logic [ACC_W-1:0] nxt;
  logic [ACC_W-1:0] acc_q;

  always_comb begin
    raw = val[ACC_W-1:0];
    if (hi_only)
      cand = {raw[ACC_W-1:HALF_W], clr_dis ? acc_q[HALF_W-1:0] : {HALF_W{1'b0}}};
    else
      cand = raw;
    ovf32   = guard_mismatch(cand);
    lovf    = val[EXT_W-1] != val[ACC_W-1];
    nxt     = (ovf32 && !sat_dis) ? clamp_value(cand[ACC_W-1]) : cand;
    is_zero = (nxt == '0);
    is_neg  = nxt[ACC_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc_q <= '0;
    else if (upd) acc_q <= nxt;
  end

  assign acc = acc_q;
endmodule

// File: rtl/acc_status_reg.sv
module acc_status_reg
  import acc_sat_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  logic [DEST_W-1:0]  op_dest,
  input  logic [NUM_ACC-1:0] ovf32,
  input  logic [NUM_ACC-1:0] lovf,
  input  logic [NUM_ACC-1:0] is_zero,
  input  logic [NUM_ACC-1:0] is_neg,
  input  logic               sw_we,
  input  logic [WORD_W-1:0]  sw_wdata,
  output logic [WORD_W-1:0]  status
);
  logic [WORD_W-1:0] st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (sw_we) begin
      st_q <= sw_wdata;
    end else if (op_valid) begin
      st_q[ST_NEG]  <= is_neg[op_dest];
      st_q[ST_ZERO] <= is_zero[op_dest];
      st_q[ST_LOVF] <= lovf[op_dest];
      for (int i = 0; i < NUM_ACC; i++) begin
        if (op_dest == DEST_W'(i)) st_q[OVF_POS[i]] <= ovf32[i];
      end
    end
  end

  assign status = st_q;
endmodule

// File: rtl/acc_sat_unit.sv
module acc_sat_unit
  import acc_sat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [DEST_W-1:0] op_dest,
  input  logic              op_src_prod,
  input  logic              op_hi_only,
  input  logic [PROD_W-1:0] op_prod,
  input  logic [EXT_W-1:0]  op_res,
  input  logic              ctl_we,
  input  logic [WORD_W-1:0] ctl_wdata,
  input  logic              sw_we,
  input  logic [WORD_W-1:0] sw_wdata,
  output logic [ACC_W-1:0]  acc0,
  output logic [ACC_W-1:0]  acc1,
  output logic [WORD_W-1:0] status,
  output logic [WORD_W-1:0] ctl
);
  align_e                         align_mode;
  logic [NUM_ACC-1:0]             sat_dis;
  logic [NUM_ACC-1:0]             clr_dis;
  logic [EXT_W-1:0]               op_val;
  logic [NUM_ACC-1:0][ACC_W-1:0]  acc_bus;
  // events brought out for the checker
  logic [NUM_ACC-1:0]             ovf_evt;
  logic [NUM_ACC-1:0]             lovf_evt;
  logic [NUM_ACC-1:0]             zero_evt;
  logic [NUM_ACC-1:0]             neg_evt;

  acc_ctl_reg u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (ctl_we),
    .wdata      (ctl_wdata),
    .ctl        (ctl),
    .align_mode (align_mode),
    .sat_dis    (sat_dis),
    .clr_dis    (clr_dis)
  );

  assign op_val = op_src_prod ? align_product(op_prod, align_mode) : op_res;

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_lane
    acc_lane #(.IDX(g)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd     (op_valid && (op_dest == DEST_W'(g))),
      .val     (op_val),
      .hi_only (op_hi_only),
      .sat_dis (sat_dis[g]),
      .clr_dis (clr_dis[g]),
      .acc     (acc_bus[g]),
      .ovf32   (ovf_evt[g]),
      .lovf    (lovf_evt[g]),
      .is_zero (zero_evt[g]),
      .is_neg  (neg_evt[g])
    );
  end

  acc_status_reg u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_dest  (op_dest),
    .ovf32    (ovf_evt),
    .lovf     (lovf_evt),
    .is_zero  (zero_evt),
    .is_neg   (neg_evt),
    .sw_we    (sw_we),
    .sw_wdata (sw_wdata),
    .status   (status)
  );

  assign acc0 = acc_bus[0];
  assign acc1 = acc_bus[1];
endmodule

// File: rtl/acc_sat_chk.sv
module acc_sat_chk
  import acc_sat_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               op_valid,
  input logic [DEST_W-1:0]  op_dest,
  input logic               sw_we,
  input logic [WORD_W-1:0]  sw_wdata,
  input logic [WORD_W-1:0]  ctl,
  input logic [WORD_W-1:0]  status,
  input logic [ACC_W-1:0]   acc0,
  input logic [ACC_W-1:0]   acc1,
  input logic [NUM_ACC-1:0] ovf_evt
);
  AST_CTL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctl[WORD_W-1:CTL_USED] == '0); // R2

  AST_A0_SAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_dest == 1'b0 && !ctl[CTL_SAT_LO]
    |=> acc0[ACC_W-1:PROD_W] == {GUARD_W{acc0[PROD_W-1]}}); // R5

  AST_A0_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !sw_we && op_dest == 1'b0 |=> status[9] == $past(ovf_evt[0])); // R4

  AST_A1_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !sw_we && op_dest == 1'b1 |=> status[4] == $past(ovf_evt[1])); // R4

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !sw_we
    |=> status[ST_ZERO] == ((($past(op_dest) == 1'b0) ? acc0 : acc1) == '0)); // R7

  AST_NEG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !sw_we
    |=> status[ST_NEG] == (($past(op_dest) == 1'b0) ? acc0[ACC_W-1] : acc1[ACC_W-1])); // R7

  AST_SW_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we |=> status == $past(sw_wdata)); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid && !sw_we |=> $stable(status) && $stable(acc0) && $stable(acc1)); // R10
endmodule

bind acc_sat_unit acc_sat_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .op_dest  (op_dest),
  .sw_we    (sw_we),
  .sw_wdata (sw_wdata),
  .ctl      (ctl),
  .status   (status),
  .acc0     (acc0),
  .acc1     (acc1),
  .ovf_evt  (ovf_evt)
);

// File: tb/acc_sat_unit_bench.sv
`timescale 1ns/1ps
module acc_sat_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [0:0]  op_dest = 1'b0;
  logic        op_src_prod = 1'b0;
  logic        op_hi_only = 1'b0;
  logic [31:0] op_prod = '0;
  logic [36:0] op_res = '0;
  logic        ctl_we = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic        sw_we = 1'b0;
  logic [15:0] sw_wdata = '0;
  logic [35:0] acc0, acc1;
  logic [15:0] status, ctl;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  acc_sat_unit u_acc_sat_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_dest(op_dest),
    .op_src_prod(op_src_prod), .op_hi_only(op_hi_only), .op_prod(op_prod),
    .op_res(op_res), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .sw_we(sw_we),
    .sw_wdata(sw_wdata), .acc0(acc0), .acc1(acc1), .status(status), .ctl(ctl)
  );

  typedef struct packed {
    logic [8:0]  c;
    logic        d;
    logic        sp;
    logic [31:0] p;
    logic [36:0] r;
    logic [35:0] ea;
    logic        eo;
    logic        el;
    logic        ez;
    logic        en;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{9'h000, 1'b0, 1'b1, 32'h0000_1234, 37'h0, 36'h0_0000_1234, 1'b0, 1'b0, 1'b0, 1'b0},
    '{9'h001, 1'b1, 1'b1, 32'hFFFF_FFF0, 37'h0, 36'hF_FFFF_FFFC, 1'b0, 1'b0, 1'b0, 1'b1},
    '{9'h002, 1'b0, 1'b1, 32'h4000_0000, 37'h0, 36'h0_7FFF_FFFF, 1'b1, 1'b0, 1'b0, 1'b0},
    '{9'h003, 1'b1, 1'b1, 32'h8000_0000, 37'h0, 36'hF_8000_0000, 1'b1, 1'b0, 1'b0, 1'b1},
    '{9'h00E, 1'b0, 1'b1, 32'h4000_0000, 37'h0, 36'h1_0000_0000, 1'b1, 1'b0, 1'b0, 1'b0},
    '{9'h000, 1'b0, 1'b0, 32'h0, 37'h0, 36'h0, 1'b0, 1'b0, 1'b1, 1'b0},
    '{9'h000, 1'b1, 1'b0, 32'h0, 37'h0_8_0000_0000, 36'hF_8000_0000, 1'b1, 1'b1, 1'b0, 1'b1},
    '{9'h008, 1'b1, 1'b0, 32'h0, 37'h1_F_FFFF_FFFF, 36'hF_FFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    op_valid = 1'b0; op_hi_only = 1'b0; op_src_prod = 1'b0;
    ctl_we = 1'b0; sw_we = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_ctl(input logic [15:0] v);
    @(negedge clk);
    idle_inputs();
    ctl_we = 1'b1; ctl_wdata = v;
    tick();
  endtask

  task automatic wr_sw(input logic [15:0] v);
    @(negedge clk);
    idle_inputs();
    sw_we = 1'b1; sw_wdata = v;
    tick();
  endtask

  task automatic do_op(input logic d, input logic sp, input logic hi,
                       input logic [31:0] p, input logic [36:0] r);
    @(negedge clk);
    idle_inputs();
    op_valid = 1'b1; op_dest = d; op_src_prod = sp; op_hi_only = hi;
    op_prod = p; op_res = r;
    tick();
  endtask

  initial begin
    #500000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [35:0] s0, s1;
    logic [15:0] ss;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    check("R1 acc0", 64'(acc0), 64'h0);
    check("R1 acc1", 64'(acc1), 64'h0);
    check("R1 status", 64'(status), 64'h0);
    check("R1 ctl", 64'(ctl), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: reserved control bits
    wr_ctl(16'hFFFF);
    check("R2 ctl readback", 64'(ctl), 64'h01FF);

    // vector table: R3 alignment, R4/R5 overflow and clamp, R6 carry, R7 flags
    for (int i = 0; i < NV; i++) begin
      wr_ctl({7'b0, VECS[i].c});
      do_op(VECS[i].d, VECS[i].sp, 1'b0, VECS[i].p, VECS[i].r);
      check("R3 R5 acc value", 64'(VECS[i].d ? acc1 : acc0), 64'(VECS[i].ea));
      check("R4 ovf flag", 64'(VECS[i].d ? status[4] : status[9]), 64'(VECS[i].eo));
      check("R6 carry flag", 64'(status[13]), 64'(VECS[i].el));
      check("R7 zero flag", 64'(status[14]), 64'(VECS[i].ez));
      check("R7 neg flag", 64'(status[15]), 64'(VECS[i].en));
    end

    // R8: high-part loads
    wr_ctl(16'h0000);
    do_op(1'b0, 1'b0, 1'b0, 32'h0, 37'h0_0000_BEEF);
    do_op(1'b0, 1'b0, 1'b1, 32'h0, 37'h0_1234_5678);
    check("R8 a0 low cleared", 64'(acc0), 64'h0_1234_0000);
    wr_ctl(16'h0010);
    do_op(1'b0, 1'b0, 1'b0, 32'h0, 37'h0_0000_BEEF);
    do_op(1'b0, 1'b0, 1'b1, 32'h0, 37'h0_5555_0000);
    check("R8 a0 low kept", 64'(acc0), 64'h0_5555_BEEF);
    wr_ctl(16'h0040);
    do_op(1'b0, 1'b0, 1'b0, 32'h0, 37'h0_0000_BEEF);
    do_op(1'b0, 1'b0, 1'b1, 32'h0, 37'h0_7777_1111);
    check("R8 bit6 no effect", 64'(acc0), 64'h0_7777_0000);
    wr_ctl(16'h0020);
    do_op(1'b1, 1'b0, 1'b0, 32'h0, 37'h0_0000_1111);
    do_op(1'b1, 1'b0, 1'b1, 32'h0, 37'h0_2222_9999);
    check("R8 a1 low kept", 64'(acc1), 64'h0_2222_1111);

    // R9: status write
    wr_sw(16'hA5A5);
    check("R9 status write", 64'(status), 64'hA5A5);
    @(negedge clk);
    idle_inputs();
    sw_we = 1'b1; sw_wdata = 16'h1234;
    op_valid = 1'b1; op_dest = 1'b0; op_res = 37'h0;
    tick();
    check("R9 write wins", 64'(status), 64'h1234);
    check("R9 acc still written", 64'(acc0), 64'h0);

    // R4: flag of other accumulator untouched
    wr_sw(16'h0000);
    wr_ctl(16'h0000);
    do_op(1'b0, 1'b0, 1'b0, 32'h0, 37'h0_1_0000_0000);
    check("R4 a0 ovf set", 64'(status[9]), 64'h1);
    check("R5 a0 clamp pos", 64'(acc0), 64'h0_7FFF_FFFF);
    do_op(1'b1, 1'b0, 1'b0, 32'h0, 37'h0_0000_0005);
    check("R4 a0 ovf kept", 64'(status[9]), 64'h1);
    check("R4 a1 ovf clear", 64'(status[4]), 64'h0);

    // R10: hold without strobe
    s0 = acc0; s1 = acc1; ss = status;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      idle_inputs();
      op_dest = 1'(k); op_res = 37'h1_2345_6789 + 37'(k); op_prod = 32'hDEAD_0000;
      tick();
    end
    check("R10 acc0 hold", 64'(acc0), 64'(s0));
    check("R10 acc1 hold", 64'(acc1), 64'(s1));
    check("R10 status hold", 64'(status), 64'(ss));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule